// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus-fetch engine and an instruction consumer. It keeps up to six bytes of instruction stream, taken from memory ahead of use, and hands them out one byte at a time in fetch order. Whenever enough room is free it reads another 16-bit word over a simple request/acknowledge bus port. The same port also carries operand reads and writes for the consumer. An operand request waits for a fetch that is already on the bus, and it wins over a fetch that has not started yet.

A branch is signalled with a one-cycle flush pulse that carries the target address. The flush empties the queue and moves the fetch pointer to the target. Any fetch still on the bus at that moment completes on the bus, but its data is thrown away. If the target is odd, one byte is fetched first so that every later fetch is word aligned. A two-bit status output reports, one cycle later, what happened to the queue in each cycle.

Top module: `ifetch_queue`

## Requirements
- R1: While reset is held, `bus_req`, `pop_valid` and `qs` are all low.
- R2: Bytes leave the queue in address order. The queue never holds more than DEPTH (6) bytes. After reset with no consumer activity, exactly three word fetches are made, at addresses 0, 2 and 4.
- R3: A word fetch starts only when at least two slots are free and no operand request is waiting. An even fetch delivers the byte at the even address first and the odd byte second, then advances the pointer by 2.
- R4: A pop while `pop_valid` is low removes nothing. The next cycle's `qs` is 00, and the stream that follows is unchanged.
- R5: After a `flush` cycle, `pop_valid` is low. The bytes that follow come from `flush_addr`, `flush_addr+1`, and so on.
- R6: A fetch that is on the bus when `flush` arrives still completes on the bus, but none of its bytes enter the queue.
- R7: When the fetch pointer is odd, the fetch queues only the upper byte of the returned word (`bus_rdata[15:8]`) and the pointer advances by 1.
- R8: An operand request raised during a fetch is placed on the bus only after that fetch is acknowledged. An operand request present while the bus is idle is served before a pending fetch.
- R9: The bus holds its request, address and kind until `bus_ack`. `op_done` pulses for one cycle, the cycle after the operand acknowledge, with `op_rdata` equal to the word read. A write drives `bus_we` high with `op_wdata` on `bus_wdata`.
- R10: `qs` shows the previous cycle's queue action: 10 for a flush (which takes priority over a pop), 01 for a pop with `pop_first` high, 11 for a pop with `pop_first` low, and 00 when nothing happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Branch: empty queue, reload fetch pointer |
| flush_addr | input | ADDR_W | Branch target byte address |
| pop | input | 1 | Consumer takes the head byte |
| pop_first | input | 1 | Byte being taken is an opcode's first byte |
| pop_valid | output | 1 | Queue holds at least one byte |
| pop_data | output | 8 | Head byte |
| qs | output | 2 | Queue action of the previous cycle |
| op_req | input | 1 | Operand access request, held until op_done |
| op_we | input | 1 | Operand access is a write |
| op_addr | input | ADDR_W | Operand byte address |
| op_wdata | input | 16 | Operand write word |
| op_done | output | 1 | Operand access finished (one-cycle pulse) |
| op_rdata | output | 16 | Operand read word |
| bus_req | output | 1 | Bus transfer request |
| bus_fetch | output | 1 | Transfer is an instruction fetch |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Transfer byte address |
| bus_wdata | output | 16 | Write word |
| bus_ack | input | 1 | Transfer acknowledge, one cycle |
| bus_rdata | input | 16 | Read word, even-address byte in [7:0] |

## Verification
The hardest case to reach from the ports is a flush that lands while a fetch is still waiting on the bus, because the stale word then arrives after the pointer has already moved. The bench gets there with a bus responder whose latency is swept from 0 to 3 cycles. It drains two bytes to start a refill, watches for `bus_fetch` at the falling edge, and only then pulses `flush` toward odd and even targets. Operand ordering is reached the same way: the request is raised during a slow fetch, and also on the exact cycle a refill would otherwise begin.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_FETCH = 2'd1,
      ARB_OPER  = 2'd2
   } arb_state_t;

   typedef enum logic [1:0] {
      QS_NONE    = 2'b00,
      QS_FIRST   = 2'b01,
      QS_EMPTIED = 2'b10,
      QS_NEXT    = 2'b11
   } qstat_t;
endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
   parameter int DEPTH = 6,
   parameter int W     = 8,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [1:0]       push_n,
   input  logic [W-1:0]     push_lo,
   input  logic [W-1:0]     push_hi,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] level,
   output logic             pop_ok
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pfq_byte_fifo: DEPTH must hold at least one word");
      end
      if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
         $error("pfq_byte_fifo: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p, input int k);
      int s;
      s = int'(p) + k;
      if (s >= DEPTH) s = s - DEPTH;
      return PTR_W'(s);
   endfunction

   assign pop_ok = pop && (cnt_q != '0);
   assign head   = mem[rd_q];
   assign level  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (pop_ok) rd_q <= wrap_add(rd_q, 1);
         wr_q  <= wrap_add(wr_q, int'(push_n));
         cnt_q <= CNT_W'(int'(cnt_q) + int'(push_n) - (pop_ok ? 1 : 0));
      end
   end

   always_ff @(posedge clk) begin
      if (!clear) begin
         if (push_n != 2'd0) mem[wr_q] <= push_lo;
         if (push_n == 2'd2) mem[wrap_add(wr_q, 1)] <= push_hi;
      end
   end

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);
   assert_push_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && push_n != 2'd0) |-> (int'(level) + int'(push_n) <= DEPTH));
   assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (level == '0));
endmodule

// File: rtl/pfq_bus_arb.sv
module pfq_bus_arb
   import pfq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DEPTH  = 6,
   parameter int CNT_W  = 3,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  level,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic              op_req,
   input  logic              op_we,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [15:0]       op_wdata,
   output logic              op_done,
   output logic [15:0]       op_rdata,
   output logic              bus_req,
   output logic              bus_fetch,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [15:0]       bus_rdata,
   output logic [1:0]        push_n,
   output logic [7:0]        push_lo,
   output logic [7:0]        push_hi
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pfq_bus_arb: ADDR_W too small");
      end
   endgenerate

   arb_state_t        state_q;
   logic [ADDR_W-1:0] fptr_q, faddr_q, oaddr_q;
   logic [15:0]       owd_q, ordata_q;
   logic              owe_q, discard_q, done_q;
   logic              room, op_go, keep_fetch;

   assign room       = (int'(level) <= DEPTH - 2);
   assign op_go      = op_req && !done_q;
   assign keep_fetch = (state_q == ARB_FETCH) && bus_ack && !discard_q && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ARB_IDLE;
         fptr_q    <= RESET_ADDR;
         faddr_q   <= RESET_ADDR;
         oaddr_q   <= '0;
         owd_q     <= '0;
         owe_q     <= 1'b0;
         discard_q <= 1'b0;
         done_q    <= 1'b0;
         ordata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ARB_IDLE: begin
               if (op_go) begin
                  state_q <= ARB_OPER;
                  oaddr_q <= op_addr;
                  owe_q   <= op_we;
                  owd_q   <= op_wdata;
               end else if (room && !flush) begin
                  state_q <= ARB_FETCH;
                  faddr_q <= fptr_q;
               end
            end
            ARB_FETCH: begin
               if (bus_ack) begin
                  state_q   <= ARB_IDLE;
                  discard_q <= 1'b0;
                  if (keep_fetch)
                     fptr_q <= faddr_q + ADDR_W'(faddr_q[0] ? 1 : 2);
               end else if (flush) begin
                  discard_q <= 1'b1;
               end
            end
            ARB_OPER: begin
               if (bus_ack) begin
                  state_q <= ARB_IDLE;
                  done_q  <= 1'b1;
                  if (!owe_q) ordata_q <= bus_rdata;
               end
            end
            default: state_q <= ARB_IDLE;
         endcase
         if (flush) fptr_q <= flush_addr;
      end
   end

   always_comb begin
      push_n  = 2'd0;
      push_lo = bus_rdata[7:0];
      push_hi = bus_rdata[15:8];
      if (keep_fetch) begin
         if (faddr_q[0]) begin
            push_n  = 2'd1;
            push_lo = bus_rdata[15:8];
         end else begin
            push_n  = 2'd2;
         end
      end
   end

   assign bus_req   = (state_q != ARB_IDLE);
   assign bus_fetch = (state_q == ARB_FETCH);
   assign bus_we    = (state_q == ARB_OPER) && owe_q;
   assign bus_addr  = (state_q == ARB_OPER) ? oaddr_q : faddr_q;
   assign bus_wdata = owd_q;
   assign op_done   = done_q;
   assign op_rdata  = ordata_q;

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_fetch)));
   assert_fetch_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && bus_fetch) |-> (int'($past(level)) <= DEPTH - 2));
   assert_fetch_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_fetch && bus_ack && op_req && !op_done) |-> ##2 (bus_req && !bus_fetch));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |=> !op_done);
endmodule

// File: rtl/pfq_qstat.sv
module pfq_qstat
   import pfq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       pop_ok,
   input  logic       pop_first,
   output logic [1:0] qs
);
   qstat_t qs_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      qs_q <= QS_NONE;
      else if (flush)  qs_q <= QS_EMPTIED;
      else if (pop_ok) qs_q <= pop_first ? QS_FIRST : QS_NEXT;
      else             qs_q <= QS_NONE;
   end

   assign qs = qs_q;

   assert_flush_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (qs == 2'b10));
   assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !pop_ok) |=> (qs == 2'b00));
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue #(
   parameter int ADDR_W = 20,
   parameter int DEPTH  = 6,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic              pop,
   input  logic              pop_first,
   output logic              pop_valid,
   output logic [7:0]        pop_data,
   output logic [1:0]        qs,
   input  logic              op_req,
   input  logic              op_we,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [15:0]       op_wdata,
   output logic              op_done,
   output logic [15:0]       op_rdata,
   output logic              bus_req,
   output logic              bus_fetch,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [15:0]       bus_rdata
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] level;
   logic [1:0]       push_n;
   logic [7:0]       push_lo, push_hi;
   logic             pop_ok;

   pfq_byte_fifo #(.DEPTH(DEPTH), .W(8), .CNT_W(CNT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .push_n(push_n), .push_lo(push_lo), .push_hi(push_hi),
      .pop(pop), .head(pop_data), .level(level), .pop_ok(pop_ok)
   );

   pfq_bus_arb #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
                 .RESET_ADDR(RESET_ADDR)) u_arb (
      .clk(clk), .rst_n(rst_n), .level(level),
      .flush(flush), .flush_addr(flush_addr),
      .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
      .op_done(op_done), .op_rdata(op_rdata),
      .bus_req(bus_req), .bus_fetch(bus_fetch), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .push_n(push_n), .push_lo(push_lo), .push_hi(push_hi)
   );

   pfq_qstat u_qstat (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .pop_ok(pop_ok), .pop_first(pop_first), .qs(qs)
   );

   assign pop_valid = (level != '0);

   assert_empty_after_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pop_valid);
   assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !pop_valid && !flush) |=> (qs == 2'b00));
endmodule

// File: tb/test_ifetch_queue.sv
module test_ifetch_queue;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic [AW-1:0] flush_addr = '0;
   logic          pop = 1'b0, pop_first = 1'b0;
   logic          pop_valid;
   logic [7:0]    pop_data;
   logic [1:0]    qs;
   logic          op_req = 1'b0, op_we = 1'b0;
   logic [AW-1:0] op_addr = '0;
   logic [15:0]   op_wdata = '0;
   logic          op_done;
   logic [15:0]   op_rdata;
   logic          bus_req, bus_fetch, bus_we;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata;
   logic          bus_ack = 1'b0;
   logic [15:0]   bus_rdata = '0;

   int errs = 0, checks = 0, lat = 0, ntrans = 0, expa = 0;
   bit lg_fetch [256];
   bit lg_we    [256];
   int lg_addr  [256];
   int lg_wd    [256];

   always #2 clk = ~clk;

   ifetch_queue i_ifetch_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .pop(pop), .pop_first(pop_first), .pop_valid(pop_valid), .pop_data(pop_data),
      .qs(qs), .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
      .op_done(op_done), .op_rdata(op_rdata), .bus_req(bus_req), .bus_fetch(bus_fetch),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   function automatic logic [7:0] cb(input int a);
      return 8'((a * 13 + 7) & 255);
   endfunction
   function automatic logic [15:0] oprd(input int a);
      return 16'(((a * 37) ^ 16'h5A5A) & 16'hFFFF);
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // bus responder: ack after lat extra cycles, logs each finished transfer
   initial begin
      int w;
      w = 0;
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
            w = 0;
         end else if (bus_req && rst_n) begin
            if (w >= lat) begin
               int a;
               a = int'(bus_addr);
               bus_ack = 1'b1;
               if (bus_fetch) bus_rdata = {cb(a | 1), cb(a & ~1)};
               else           bus_rdata = oprd(a);
               lg_fetch[ntrans % 256] = bus_fetch;
               lg_we[ntrans % 256]    = bus_we;
               lg_addr[ntrans % 256]  = a;
               lg_wd[ntrans % 256]    = int'(bus_wdata);
               ntrans++;
            end else begin
               w++;
            end
         end
      end
   end

   task automatic take(input int a, input bit first, input string req);
      @(negedge clk);
      while (!pop_valid) @(negedge clk);
      chk(pop_data == cb(a), req, "popped byte", int'(pop_data), int'(cb(a)));
      pop = 1'b1;
      pop_first = first;
      @(posedge clk);
      #1;
      pop = 1'b0;
      pop_first = 1'b0;
      chk(qs == (first ? 2'b01 : 2'b11), "R10", "qs after pop", int'(qs), first ? 1 : 3);
   endtask

   task automatic operand(input bit we, input int a, input int wd, output int rd);
      @(negedge clk);
      op_req = 1'b1;
      op_we = we;
      op_addr = AW'(a);
      op_wdata = 16'(wd);
      @(negedge clk);
      while (!op_done) @(negedge clk);
      rd = int'(op_rdata);
      op_req = 1'b0;
      op_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      int n0, rd;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!bus_req, "R1", "bus_req in reset", int'(bus_req), 0);
      chk(!pop_valid, "R1", "pop_valid in reset", int'(pop_valid), 0);
      chk(qs == 2'b00, "R1", "qs in reset", int'(qs), 0);
      rst_n = 1'b1;

      // R2/R3: fill with no consumer -> three word fetches at 0,2,4
      repeat (40) @(negedge clk);
      chk(ntrans == 3, "R2", "fetches to fill", ntrans, 3);
      for (int i = 0; i < 3; i++)
         chk(lg_fetch[i] && lg_addr[i] == 2 * i, "R3", "fill fetch address", lg_addr[i], 2 * i);

      // R2/R10: ordered stream, mixed first flags
      for (int i = 0; i < 20; i++) take(expa + i, (i % 4) == 0, "R2");
      expa = 20;

      // R8: operand wins over a fetch that is about to start
      repeat (40) @(negedge clk);
      take(expa, 1'b1, "R2");
      take(expa + 1, 1'b0, "R2");
      expa += 2;
      n0 = ntrans;
      operand(1'b0, 'h1234, 0, rd);
      chk(!lg_fetch[n0 % 256] && lg_addr[n0 % 256] == 'h1234, "R8",
          "idle operand first", lg_addr[n0 % 256], 'h1234);
      chk(rd == int'(oprd('h1234)), "R9", "operand read data", rd, int'(oprd('h1234)));
      for (int i = 0; i < 6; i++) take(expa + i, 1'b0, "R3");
      expa += 6;

      // R8: operand during an in-flight fetch waits for it
      lat = 3;
      take(expa, 1'b1, "R3");
      take(expa + 1, 1'b0, "R3");
      expa += 2;
      @(negedge clk);
      while (!(bus_req && bus_fetch)) @(negedge clk);
      n0 = ntrans;
      operand(1'b1, 'h0ABC, 'hBEEF, rd);
      chk(lg_fetch[n0 % 256], "R8", "in-flight fetch finishes first", int'(lg_fetch[n0 % 256]), 1);
      chk(!lg_fetch[(n0 + 1) % 256] && lg_addr[(n0 + 1) % 256] == 'h0ABC, "R8",
          "operand follows fetch", lg_addr[(n0 + 1) % 256], 'h0ABC);
      chk(lg_we[(n0 + 1) % 256] && lg_wd[(n0 + 1) % 256] == 'hBEEF, "R9",
          "operand write data", lg_wd[(n0 + 1) % 256], 'hBEEF);
      for (int i = 0; i < 6; i++) take(expa + i, 1'b0, "R6");
      expa += 6;

      // R4..R7, R10: flush sweep over latency and target alignment
      for (int l = 0; l < 4; l++) begin
         for (int t = 0; t < 4; t++) begin
            int tgt;
            lat = l;
            tgt = 'h300 + 5 * t + 16 * l;
            take(expa, 1'b0, "R2");
            take(expa + 1, 1'b0, "R2");
            @(negedge clk);
            while (!(bus_req && bus_fetch)) @(negedge clk);
            flush = 1'b1;
            flush_addr = AW'(tgt);
            pop = 1'b1;
            pop_first = 1'b1;
            @(posedge clk);
            #1;
            flush = 1'b0;
            pop = 1'b0;
            pop_first = 1'b0;
            chk(qs == 2'b10, "R10", "qs after flush with pop", int'(qs), 2);
            @(negedge clk);
            chk(!pop_valid, "R5", "empty after flush", int'(pop_valid), 0);
            pop = 1'b1;
            pop_first = 1'b1;
            @(posedge clk);
            #1;
            pop = 1'b0;
            pop_first = 1'b0;
            chk(qs == 2'b00, "R4", "qs after empty pop", int'(qs), 0);
            for (int i = 0; i < 8; i++)
               take(tgt + i, i == 0, (tgt % 2 == 1) ? "R7" : "R6");
            expa = tgt + 8;
         end
      end
      finish_run();
   end
endmodule